// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a small sequential controller that collects coin values until the amount paid covers the price of an item. It then raises a one-cycle dispense signal. A one-bit strobe marks that a coin is present, and a multi-bit value gives that coin's worth. The item price arrives as a runtime input of the same width. A running total is kept inside the block and is never exposed at its ports.

The controller is a four-state machine that steps through clearing, idling, accumulating and dispensing. An unsigned adder and comparator sit beside the total register and form its datapath. The block steps back to its clearing state after every dispense, so each purchase starts from zero. Coin validation, change return, strobe debouncing and any display belong to neighbouring logic.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in its clearing state with dispense low. Any amount collected before the reset is discarded.
- R2: After reset is released, the machine spends exactly one cycle clearing, with dispense low, and then idles.
- R3: While idling, a high coin strobe moves the machine into a single accumulate cycle. In that cycle the coin value present is added to the total, and the machine then idles again. A strobe held high is therefore counted once every two cycles.
- R4: While idling, a coin strobe takes priority over the dispense decision, even when the total already covers the price.
- R5: While idling with no coin strobe and with total >= price (unsigned), dispense goes high in the next cycle, for exactly one cycle.
- R6: While idling with no coin strobe and with total < price, the machine keeps idling and dispense stays low.
- R7: After a dispense cycle the machine clears the total, so coins already counted do not carry over to the next purchase.
- R8: The total is a DATA_W-bit unsigned value that wraps modulo 2^DATA_W on overflow (256 at the default width of 8), and no overflow indication is given.
- R9: With a price of 0 and no coins, the machine repeats clear, idle and dispense, so dispense is high once every three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| coin_stb | input | 1 | High while a coin is present |
| coin_val | input | DATA_W | Unsigned worth of the present coin |
| price | input | DATA_W | Unsigned price of the selected item |
| dispense | output | 1 | Registered one-cycle dispense pulse |

## Verification
The bench builds the block with its default width of 8 bits. At that width, full-scale prices such as 255 and wraparound of the total past 256 both occur within two or three coins. A table of coin sequences covers exact, overshooting, short and wrapped totals. Directed tests cover a held strobe, coin priority over a covered price, a reset in the middle of a purchase, clearing between purchases and the zero-price cycle.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_WAIT = 2'd1,
    ST_ADD  = 2'd2,
    ST_DISP = 2'd3
  } vend_state_e;
endpackage

// File: rtl/vend_total.sv
module vend_total #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] coin_val_i,
  input  logic [DATA_W-1:0] price_i,
  output logic              reached_o
);
  logic [DATA_W-1:0] total_q;
  logic [DATA_W-1:0] sum;

  // Modulo-2^DATA_W accumulation: carry out is dropped.
  assign sum       = total_q + coin_val_i;
  assign reached_o = (total_q >= price_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      total_q <= '0;
    end else if (add_i) begin
      total_q <= sum;
    end
  end

  // R7
  total_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (total_q == '0));

  // R6
  total_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !add_i) |=> $stable(total_q));
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic coin_i,
  input  logic reached_i,
  output logic clr_o,
  output logic add_o,
  output logic disp_o
);
  vend_state_e state_q, state_d;
  logic        disp_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT: state_d = ST_WAIT;
      ST_WAIT: begin
        if (coin_i)         state_d = ST_ADD;
        else if (reached_i) state_d = ST_DISP;
        else                state_d = ST_WAIT;
      end
      ST_ADD:  state_d = ST_WAIT;
      ST_DISP: state_d = ST_INIT;
      default: state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
      disp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      disp_q  <= (state_d == ST_DISP);
    end
  end

  assign clr_o  = (state_q == ST_INIT);
  assign add_o  = (state_q == ST_ADD);
  assign disp_o = disp_q;

  // R1
  reset_to_init_chk: assert property (@(posedge clk)
    rst |=> (state_q == ST_INIT && !disp_q));

  // R3
  add_back_to_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ADD) |=> (state_q == ST_WAIT));

  // R4
  coin_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && coin_i) |=> (state_q == ST_ADD && !disp_q));

  // R5
  disp_single_chk: assert property (@(posedge clk) disable iff (rst)
    disp_q |=> !disp_q);

  // R6
  idle_short_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !coin_i && !reached_i) |=> (state_q == ST_WAIT && !disp_q));
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coin_stb,
  input  logic [DATA_W-1:0] coin_val,
  input  logic [DATA_W-1:0] price,
  output logic              dispense
);
  logic clr;
  logic add;
  logic reached;

  vend_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .coin_i    (coin_stb),
    .reached_i (reached),
    .clr_o     (clr),
    .add_o     (add),
    .disp_o    (dispense)
  );

  vend_total #(.DATA_W(DATA_W)) u_total (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (clr),
    .add_i      (add),
    .coin_val_i (coin_val),
    .price_i    (price),
    .reached_o  (reached)
  );

  // R5
  disp_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dispense) |-> $past(!coin_stb));
endmodule

// File: tb/test_coin_vend_ctrl.sv
module test_coin_vend_ctrl;
  localparam int W = 8;

  typedef struct packed {
    logic [W-1:0]      price;
    logic [2:0]        ncoin;
    logic [3:0][W-1:0] coins;
    logic [2:0]        fire;   // coin index that completes payment, 7 = none
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd50,  3'd2, {8'd0,   8'd0,   8'd25,  8'd25 }, 3'd1},
    '{8'd100, 3'd4, {8'd50,  8'd30,  8'd20,  8'd10 }, 3'd3},
    '{8'd30,  3'd1, {8'd0,   8'd0,   8'd0,   8'd40 }, 3'd0},
    '{8'd200, 3'd3, {8'd0,   8'd20,  8'd50,  8'd100}, 3'd7},
    '{8'd250, 3'd4, {8'd10,  8'd200, 8'd100, 8'd200}, 3'd3},
    '{8'd255, 3'd1, {8'd0,   8'd0,   8'd0,   8'd255}, 3'd0},
    '{8'd1,   3'd2, {8'd0,   8'd0,   8'd1,   8'd0  }, 3'd1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         coin_stb = 1'b0;
  logic [W-1:0] coin_val = '0;
  logic [W-1:0] price = '0;
  logic         dispense;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  coin_vend_ctrl #(.DATA_W(W)) i_coin_vend_ctrl (
    .clk      (clk),
    .rst      (rst),
    .coin_stb (coin_stb),
    .coin_val (coin_val),
    .price    (price),
    .dispense (dispense)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: dispense=%b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Returns at a falling edge with the machine idling.
  task automatic do_reset();
    @(negedge clk); rst = 1'b1; coin_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(dispense, 1'b0, "R1 reset");
    rst = 1'b0;
    chk(dispense, 1'b0, "R2 clear cycle");
    @(negedge clk);
    chk(dispense, 1'b0, "R2 idle");
  endtask

  // One-cycle coin strobe; returns one cycle after the machine idles again.
  task automatic insert_coin(input logic [W-1:0] v);
    coin_stb = 1'b1; coin_val = v;
    @(negedge clk);
    coin_stb = 1'b0;
    chk(dispense, 1'b0, "R3 accumulate");
    @(negedge clk);
    chk(dispense, 1'b0, "R3 back to idle");
    @(negedge clk);
  endtask

  initial begin
    // Table of coin sequences (R5, R6, R8)
    for (int v = 0; v < NV; v++) begin
      price = VECS[v].price;
      do_reset();
      for (int c = 0; c < int'(VECS[v].ncoin); c++) begin
        insert_coin(VECS[v].coins[c]);
        chk(dispense, (c == int'(VECS[v].fire)), "R5/R6/R8 table");
      end
      if (VECS[v].fire != 3'd7) begin
        @(negedge clk);
        chk(dispense, 1'b0, "R5 single cycle");
      end
    end

    // R7: total restarts after a purchase
    price = 8'd50;
    do_reset();
    insert_coin(8'd25);
    insert_coin(8'd25);
    chk(dispense, 1'b1, "R7 first purchase");
    @(negedge clk);
    @(negedge clk);
    insert_coin(8'd25);
    chk(dispense, 1'b0, "R7 cleared total");
    insert_coin(8'd25);
    chk(dispense, 1'b1, "R7 second purchase");

    // R1: reset in the middle of a purchase discards the amount
    price = 8'd50;
    do_reset();
    insert_coin(8'd30);
    chk(dispense, 1'b0, "R1 partial");
    do_reset();
    insert_coin(8'd30);
    chk(dispense, 1'b0, "R1 discarded");
    insert_coin(8'd20);
    chk(dispense, 1'b1, "R1 fresh total");

    // R3: held strobe counts once every two cycles
    price = 8'd30;
    do_reset();
    coin_stb = 1'b1; coin_val = 8'd10;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(dispense, 1'b0, "R3 held strobe");
    end
    coin_stb = 1'b0;
    @(negedge clk);
    chk(dispense, 1'b0, "R3 held counted twice");
    insert_coin(8'd10);
    chk(dispense, 1'b1, "R3 held total 30");

    // R4: coin wins over a covered price
    price = 8'd100;
    do_reset();
    insert_coin(8'd60);
    chk(dispense, 1'b0, "R6 short");
    price = 8'd50;
    coin_stb = 1'b1; coin_val = 8'd5;
    @(negedge clk);
    coin_stb = 1'b0;
    chk(dispense, 1'b0, "R4 coin priority");
    @(negedge clk);
    chk(dispense, 1'b0, "R4 back to idle");
    @(negedge clk);
    chk(dispense, 1'b1, "R4 dispense after add");

    // R9: zero price cycles clear, idle, dispense
    price = 8'd0;
    do_reset();
    @(negedge clk); chk(dispense, 1'b1, "R9 pulse 1");
    @(negedge clk); chk(dispense, 1'b0, "R9 clear");
    @(negedge clk); chk(dispense, 1'b0, "R9 idle");
    @(negedge clk); chk(dispense, 1'b1, "R9 pulse 2");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule